// File: doc/BRIEF.md
# Serial Receive Port with Entry Queue

This block receives asynchronous serial characters on a single input line and holds them in a queue for software to read through four word registers. The line format is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The bit rate comes from a programmable divisor that sets the period of a sixteen-times oversampling tick. Each queued entry carries the received byte together with two error flags, one for a bad stop bit and one for a parity mismatch.

Software picks the parity mode, the divisor and a byte-count threshold. The interrupt line rises once the number of queued entries reaches the threshold, and only while the interrupt enable bit is set. Software reads entries one at a time from the data register. It can empty the queue with a self-clearing flush bit and can read status bits that show fill state, overrun and the pending request.

Register addresses: 0 control, 1 rate/count, 2 status, 3 data. All registers are 16 bits wide. Read data is combinational from the address, and read side effects take place at the clock edge while `rd_en` is high.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, control reads 0x0000, rate/count reads 0x00D8, status reads 0x0000 and `irq` is low.
- R2: A frame made of a low start bit, eight data bits (LSB first) and a high stop bit queues one entry, and the data register returns the byte in bits [7:0] with bits 15 and 14 clear.
- R3: A low pulse on the line that has ended before the mid-point of the start bit (the 8th oversampling tick) queues nothing.
- R4: Control bits [1:0] select the parity mode: 0 none, 1 odd, 2 even, 3 treated as none. With parity on, a parity bit follows the data, and a mismatch sets bit 14 of that entry's data word.
- R5: A stop bit sampled low sets bit 15 of that entry's data word, and the byte is still delivered in bits [7:0].
- R6: The queue returns up to 16 entries in arrival order, and status bit 1 is set while it holds 16.
- R7: A byte that arrives while the queue is full is dropped and sets status bit 2, which stays set until a status read clears it.
- R8: Reading the data register while the queue is empty returns 0x0000 and changes neither the queue nor its status.
- R9: Writing 1 to control bit 5 empties the queue, and bit 5 always reads back as 0.
- R10: Rate/count bits [11:8] hold N. With control bit 4 set, `irq` goes high once N+1 entries are queued.
- R11: With control bit 4 clear, `irq` stays low but reception continues, and status bit 3 still shows the pending request (status bit 0 means not empty).
- R12: After a data read drops the entry count below N+1, `irq` and status bit 3 are low.
- R13: Rate/count bits [7:0] hold divisor D. One bit time is 16*(D+1) clock cycles, and frames sent at that rate are received correctly for different D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, triggers pop and clear-on-read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq | output | 1 | Receive interrupt request |

## Verification
The receiver is driven with frames whose bit patterns cover alternating bits, runs of ones and zeros, and values with the top or bottom bit alone set, so that a swapped bit order or an off-by-one sample shows up in the byte. Each parity mode is sent both a correct and an inverted parity bit, and one frame has a low stop bit. Together these separate parity polarity, parity placement and stop checking. A short low glitch tests start validation. Frames at two divisors tell a wrong bit-period formula apart from a correct one. Queue tests fill to 16, overflow by one, drain and read once more while empty, and the threshold tests move the count across N+1 in both directions with the enable bit both set and clear.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the serial receive port.
// Assumes 8-bit characters; the entry carries both error flags.
package serial_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              frame_err;
        logic              par_err;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/os_tick_gen.sv
// Module: oversampling tick generator.
// Emits a one-cycle tick every (divisor+1) clock cycles. Free running;
// the receiver tolerates up to one tick of start-edge jitter.
module os_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count clock cycles and pulse tick at the divisor terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_deser.sv
// Module: serial frame deserializer.
// Synchronizes the line, validates the start bit at its mid-point, samples
// data bits LSB first at their centre, checks optional parity and the stop
// bit, and pulses push with the finished entry. Assumes 16 ticks per bit.
module rx_deser
    import serial_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd_async,
    input  logic [1:0] par_mode,
    output logic      push,
    output rx_entry_t entry
);

    localparam int TW      = $clog2(OS_RATE);
    localparam int BW      = $clog2(CHAR_W);
    localparam logic [TW-1:0] T_MID  = TW'(OS_RATE/2 - 1);
    localparam logic [TW-1:0] T_LAST = TW'(OS_RATE - 1);
    localparam logic [BW-1:0] B_LAST = BW'(CHAR_W - 1);

    logic              rx_meta, rx_s;
    rx_state_e         state;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bcnt;
    logic [CHAR_W-1:0] shreg;
    logic              perr;
    logic              par_on;
    logic              par_bad;

    // Parity is active for odd and even modes only.
    always_comb begin
        par_on  = (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
        par_bad = (par_mode == PAR_ODD) ? ~(^{shreg, rx_s}) : (^{shreg, rx_s});
    end

    // Two-flop synchronizer for the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd_async;
            rx_s    <= rx_meta;
        end
    end

    // Frame state machine driven by oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bcnt  <= '0;
            shreg <= '0;
            perr  <= 1'b0;
            push  <= 1'b0;
            entry <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state <= RX_START;
                        tcnt  <= '0;
                        perr  <= 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == T_MID) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt  <= '0;
                            shreg <= {rx_s, shreg[CHAR_W-1:1]};
                            bcnt  <= bcnt + 1'b1;
                            if (bcnt == B_LAST)
                                state <= par_on ? RX_PAR : RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt  <= '0;
                            perr  <= par_bad;
                            state <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt            <= '0;
                            push            <= 1'b1;
                            entry.frame_err <= ~rx_s;
                            entry.par_err   <= perr;
                            entry.data      <= shreg;
                            state           <= rx_s ? RX_IDLE : RX_HOLD;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_HOLD: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_queue.sv
// Module: receive entry queue.
// Circular buffer with occupancy count. Push on full is dropped and
// reported on drop; pop on empty is ignored; flush empties it.
module rx_queue
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  rx_entry_t                din,
    input  logic                     pop,
    output rx_entry_t                dout,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     full,
    output logic                     empty,
    output logic                     drop
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Qualify requests against fill state.
    always_comb begin
        full    = (level == LVL_MAX);
        empty   = (level == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        drop    = push && full && !flush;
        dout    = mem[rd_ptr];
    end

    // Store pushed entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Maintain pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/serial_rx_port.sv
// Module: serial receive port top.
// Register file (control, rate/count, status, data) around the tick
// generator, deserializer and entry queue. Interrupt is pending while the
// queue holds at least count+1 entries. Assumes CNT_W <= log2(DEPTH).
module serial_rx_port
    import serial_rx_pkg::*;
#(
    parameter int               REG_W     = 16,
    parameter int               DEPTH     = 16,
    parameter int               DIV_W     = 8,
    parameter int               CNT_W     = 4,
    parameter logic [DIV_W-1:0] DIV_RESET = 8'hD8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);

    localparam int LW = $clog2(DEPTH) + 1;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_RATE = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;
    localparam int B_IEN   = 4;
    localparam int B_FLUSH = 5;

    logic [1:0]       par_mode;
    logic             irq_en;
    logic             flush_q;
    logic [DIV_W-1:0] divisor;
    logic [CNT_W-1:0] count;
    logic             overrun;
    logic             tick;
    logic             rx_push;
    rx_entry_t        rx_entry;
    rx_entry_t        q_dout;
    logic [LW-1:0]    fifo_level;
    logic             fifo_full, fifo_empty, fifo_drop;
    logic             data_pop;
    logic [LW-1:0]    thr;
    logic             pend;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1:DIV_W+CNT_W], reg_wdata[3:2]};

    // Control and rate/count registers; flush is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_mode <= PAR_NONE;
            irq_en   <= 1'b0;
            flush_q  <= 1'b0;
            divisor  <= DIV_RESET;
            count    <= '0;
        end else begin
            flush_q <= 1'b0;
            if (wr_en && reg_addr == A_CTRL) begin
                par_mode <= reg_wdata[1:0];
                irq_en   <= reg_wdata[B_IEN];
                flush_q  <= reg_wdata[B_FLUSH];
            end
            if (wr_en && reg_addr == A_RATE) begin
                divisor <= reg_wdata[DIV_W-1:0];
                count   <= reg_wdata[DIV_W +: CNT_W];
            end
        end
    end

    // Sticky overrun: set on a dropped byte, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (fifo_drop)
            overrun <= 1'b1;
        else if (rd_en && reg_addr == A_STAT)
            overrun <= 1'b0;
    end

    // Threshold compare and interrupt gating.
    always_comb begin
        data_pop = rd_en && (reg_addr == A_DATA);
        thr      = LW'(count) + 1'b1;
        pend     = (fifo_level >= thr);
        irq      = pend && irq_en;
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[1:0]   = par_mode;
                reg_rdata[B_IEN] = irq_en;
            end
            A_RATE: begin
                reg_rdata[DIV_W-1:0]     = divisor;
                reg_rdata[DIV_W +: CNT_W] = count;
            end
            A_STAT: begin
                reg_rdata[0] = !fifo_empty;
                reg_rdata[1] = fifo_full;
                reg_rdata[2] = overrun;
                reg_rdata[3] = pend;
            end
            default: begin
                if (!fifo_empty) begin
                    reg_rdata[REG_W-1]   = q_dout.frame_err;
                    reg_rdata[REG_W-2]   = q_dout.par_err;
                    reg_rdata[CHAR_W-1:0] = q_dout.data;
                end
            end
        endcase
    end

    os_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .tick    (tick)
    );

    rx_deser #(.OS_RATE(16)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd_async (rxd),
        .par_mode  (par_mode),
        .push      (rx_push),
        .entry     (rx_entry)
    );

    rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_q),
        .push  (rx_push),
        .din   (rx_entry),
        .pop   (data_pop),
        .dout  (q_dout),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty),
        .drop  (fifo_drop)
    );

endmodule

// File: rtl/serial_rx_checker.sv
// Module: assertion checker bound to the serial receive port.
// Observes queue occupancy against push, pop and flush requests.
module serial_rx_checker #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          push,
    input logic          pop,
    input logic          flush
);

    // R1: reset leaves the queue empty.
    a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> (level == '0));

    // R6: occupancy never exceeds depth.
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R2: an accepted push alone grows occupancy by one.
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (level == LW'($past(level) + 1'b1)));

    // R7: a push into a full queue leaves it full.
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R8: pop on empty keeps it empty.
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

    // R9: flush empties the queue.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

bind serial_rx_port serial_rx_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty),
    .push  (rx_push),
    .pop   (data_pop),
    .flush (flush_q)
);

// File: tb/test_serial_rx_port.sv
`timescale 1ns/1ps
module test_serial_rx_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cur_div = 1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_port i_serial_rx_port (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * 16 * (cur_div + 1)) @(negedge clk);
    endtask

    // mode: 0 none, 1 odd, 2 even
    task automatic send(input logic [7:0] b, input int mode, input bit bad_par, input bit bad_stop);
        logic p;
        @(negedge clk);
        rxd = 1'b0; wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; wait_bits(1);
        end
        if (mode == 1 || mode == 2) begin
            p = (mode == 2) ? ^b : ~(^b);
            rxd = bad_par ? ~p : p; wait_bits(1);
        end
        rxd = ~bad_stop; wait_bits(1);
        rxd = 1'b1; wait_bits(2);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); check("R1 control", v, 16'h0000);
        rd(2'd1, v); check("R1 rate", v, 16'h00D8);
        rd(2'd2, v); check("R1 status", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        wr(2'd1, 16'h0001); cur_div = 1;
        wr(2'd0, 16'h0000);
        send(8'hA5, 0, 0, 0); send(8'h3C, 0, 0, 0); send(8'h80, 0, 0, 0);
        rd(2'd3, v); check("R2 byte A5", v, 16'h00A5);
        rd(2'd3, v); check("R2 byte 3C", v, 16'h003C);
        rd(2'd3, v); check("R2 byte 80", v, 16'h0080);
    endtask

    task automatic t_glitch();
        logic [15:0] v;
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1; wait_bits(12);
        rd(2'd2, v); check("R3 glitch ignored", v, 16'h0000);
    endtask

    task automatic t_parity();
        logic [15:0] v;
        wr(2'd0, 16'h0001);
        send(8'h5A, 1, 0, 0); send(8'h5A, 1, 1, 0);
        rd(2'd3, v); check("R4 odd good", v, 16'h005A);
        rd(2'd3, v); check("R4 odd bad", v, 16'h405A);
        wr(2'd0, 16'h0002);
        send(8'h81, 2, 0, 0); send(8'h07, 2, 1, 0);
        rd(2'd3, v); check("R4 even good", v, 16'h0081);
        rd(2'd3, v); check("R4 even bad", v, 16'h4007);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_framing();
        logic [15:0] v;
        send(8'h77, 0, 0, 1);
        rd(2'd3, v); check("R5 framing", v, 16'h8077);
    endtask

    task automatic t_divisor();
        logic [15:0] v;
        wr(2'd1, 16'h0003); cur_div = 3;
        send(8'hC3, 0, 0, 0);
        rd(2'd3, v); check("R13 divisor 3", v, 16'h00C3);
        wr(2'd1, 16'h0001); cur_div = 1;
        send(8'h1E, 0, 0, 0);
        rd(2'd3, v); check("R13 divisor 1", v, 16'h001E);
    endtask

    task automatic t_full();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) send(8'(i * 13 + 1), 0, 0, 0);
        rd(2'd2, v); check("R6 full status", v, 16'h000B);
        send(8'hEE, 0, 0, 0);
        rd(2'd2, v); check("R7 overrun set", v, 16'h000F);
        rd(2'd2, v); check("R7 overrun cleared", v, 16'h000B);
        for (int i = 0; i < 16; i++) begin
            rd(2'd3, v); check("R6 order", v, {8'h00, 8'(i * 13 + 1)});
        end
        rd(2'd3, v); check("R8 empty read", v, 16'h0000);
        rd(2'd2, v); check("R8 status after empty read", v, 16'h0000);
        send(8'h42, 0, 0, 0);
        rd(2'd3, v); check("R8 pointers intact", v, 16'h0042);
    endtask

    task automatic t_flush();
        logic [15:0] v;
        send(8'h11, 0, 0, 0); send(8'h22, 0, 0, 0);
        wr(2'd0, 16'h0020);
        rd(2'd2, v); check("R9 flushed", v, 16'h0000);
        rd(2'd0, v); check("R9 bit self-clears", v, 16'h0000);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(2'd1, 16'h0201);
        wr(2'd0, 16'h0010);
        send(8'h01, 0, 0, 0); send(8'h02, 0, 0, 0);
        check("R10 irq below threshold", {15'd0, irq}, 16'h0000);
        send(8'h03, 0, 0, 0);
        check("R10 irq at threshold", {15'd0, irq}, 16'h0001);
        rd(2'd3, v); check("R12 popped", v, 16'h0001);
        check("R12 irq drops", {15'd0, irq}, 16'h0000);
        rd(2'd2, v); check("R12 pending clear", v, 16'h0001);
        wr(2'd0, 16'h0020);
    endtask

    task automatic t_masked();
        logic [15:0] v;
        wr(2'd0, 16'h0000);
        send(8'h0A, 0, 0, 0); send(8'h0B, 0, 0, 0); send(8'h0C, 0, 0, 0);
        check("R11 irq masked", {15'd0, irq}, 16'h0000);
        rd(2'd2, v); check("R11 pending shown", v, 16'h0009);
        rd(2'd3, v); check("R11 still receives", v, 16'h000A);
        rd(2'd3, v); check("R11 second", v, 16'h000B);
        rd(2'd3, v); check("R11 third", v, 16'h000C);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_glitch();
        t_parity();
        t_framing();
        t_divisor();
        t_full();
        t_flush();
        t_irq();
        t_masked();
        done = 1'b1;
        finish_run();
    end

endmodule